// File: doc/BRIEF.md
# Sub-Cycle Dithered PWM Generator

This block makes an 8-bit pulse-width waveform whose full period of 256 clocks is cut into equal modulation slices. The effective output frequency is therefore a multiple of the period rate. The duty word is split into two parts. The upper part is a base high time that every slice receives. The lower part is an extension count that adds one extra high clock to the first few slices of the period. Across one full period the total high time equals the duty word. However, the energy is spread over several short pulses rather than one long one.

Two split modes are selectable. The four-slice mode uses 64-clock slices, with a 6-bit base and a 2-bit extension. The two-slice mode uses 128-clock slices, with a 7-bit base and a 1-bit extension. The duty word and the mode are captured only when a period begins. A port data bit acts as an on/off gate on the waveform. When the generator is disabled, the pin simply carries that data bit, as a general-purpose output would.

The control is a three-state machine. ST_OFF is the disabled state, ST_HIGH means the current clock drives a high pulse, and ST_LOW means it drives a low one. The transitions are:
- T_START: ST_OFF to ST_HIGH or ST_LOW, taken on the first edge with the enable set. A fresh period starts at that edge.
- T_RISE and T_FALL: movement between ST_HIGH and ST_LOW, decided by the slice comparison for the next count.
- T_STOP: any state to ST_OFF, taken at the first edge with the enable clear.

Top module: `pwm_dither_gen`

## Requirements
- R1: While the generator is in ST_OFF with pwm_en high (before the first clock edge after enabling), pwm_out is 0. The first edge with pwm_en high starts a period with count 0, and the count then advances by one per clock and wraps from 255 to 0.
- R2: With mode_sel = 0 (four slices), the slice index is count[7:6], the position is count[5:0], the base is duty[7:2] and the extension is duty[1:0]. In slice i, the output is high while position < base + 1 if i < extension, and while position < base otherwise.
- R3: With mode_sel = 1 (two slices), the slice index is count[7], the position is count[6:0], the base is duty[7:1] and the extension is duty[0], and the same high-time rule as R2 applies.
- R4: With port_bit held at 1, the number of high clocks in one full period equals the duty value captured for that period, in both modes, from 0 to 255.
- R5: duty and mode_sel are captured only at the edge that makes the count 0. Changes at any other time have no effect until the next period starts.
- R6: While enabled, port_bit = 0 forces pwm_out to 0, and port_bit = 1 lets the waveform through.
- R7: While pwm_en is 0, pwm_out equals port_bit. Enabling again starts a fresh period from count 0 with newly captured duty and mode.
- R8: During and after reset with pwm_en low, the machine is in ST_OFF and pwm_out equals port_bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0: four 64-clock slices, 1: two 128-clock slices |
| duty | input | 8 | Duty word (base and extension) |
| pwm_en | input | 1 | Generator enable |
| port_bit | input | 1 | Port data bit, used as gate or as plain output |
| pwm_out | output | 1 | Pin value |

## Verification
Every duty value is swept in both modes, and the high clocks of each period are counted. This catches a design that puts the extension on the wrong slices, or uses `<=` in the slice comparison (which would give one extra high clock per slice), or fails to reach full high at the 255 corner. Each sweep changes the duty word one clock into the period. A design that loads the word at once would therefore show the next period's pattern early. The mode is also switched mid-period. The enable is dropped in the middle of a period and then raised again, which exposes a counter that resumes where it stopped instead of restarting. Finally, port_bit is toggled while the generator runs, which shows whether the gate is ignored or inverted.

// File: rtl/pwm_dith_pkg.sv
package pwm_dith_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } pwm_state_e;

    typedef enum logic {
        MODE_FOUR = 1'b0,
        MODE_TWO  = 1'b1
    } split_mode_e;

endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          run,
    output logic [DW-1:0] cnt_nxt,
    output logic          period_start
);

    logic [DW-1:0] cnt;

    always_comb begin
        cnt_nxt      = run ? cnt + {{(DW-1){1'b0}}, 1'b1} : '0;
        period_start = (cnt_nxt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (en)
            cnt <= cnt_nxt;
        else
            cnt <= '0;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run) ##1 en |-> cnt == $past(cnt) + {{(DW-1){1'b0}}, 1'b1}); // R1

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == '0); // R7

endmodule

// File: rtl/pwm_duty_shadow.sv
module pwm_duty_shadow
    import pwm_dith_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] duty_in,
    input  split_mode_e   mode_in,
    output logic [DW-1:0] eff_duty,
    output split_mode_e   eff_mode
);

    logic [DW-1:0] sh_duty;
    split_mode_e   sh_mode;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_duty <= '0;
            sh_mode <= MODE_FOUR;
        end else if (load) begin
            sh_duty <= duty_in;
            sh_mode <= mode_in;
        end
    end

    always_comb begin
        eff_duty = load ? duty_in : sh_duty;
        eff_mode = load ? mode_in : sh_mode;
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(sh_duty) && $stable(sh_mode))); // R5

endmodule

// File: rtl/pwm_slice_cmp.sv
module pwm_slice_cmp
    import pwm_dith_pkg::*;
#(
    parameter int DW    = 8,
    parameter int EXT_A = 2,
    parameter int EXT_B = 1
) (
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] duty,
    input  split_mode_e   mode,
    output logic          hi
);

    localparam int NMODE = 2;

    logic [NMODE-1:0] hi_m;

    for (genvar m = 0; m < NMODE; m++) begin : g_mode
        localparam int E  = (m == 0) ? EXT_A : EXT_B;
        localparam int PW = DW - E;
        localparam logic [DW-1:0] PMASK = {{E{1'b0}}, {PW{1'b1}}};
        localparam logic [DW-1:0] EMASK = {{PW{1'b0}}, {E{1'b1}}};

        logic [DW-1:0] sub_v;
        logic [DW-1:0] pos_v;
        logic [DW-1:0] base_v;
        logic [DW-1:0] ext_v;
        logic [DW:0]   len_v;

        always_comb begin
            sub_v   = cnt >> PW;
            pos_v   = cnt & PMASK;
            base_v  = duty >> E;
            ext_v   = duty & EMASK;
            len_v   = {1'b0, base_v} + {{DW{1'b0}}, (sub_v < ext_v)};
            hi_m[m] = ({1'b0, pos_v} < len_v);
        end
    end

    always_comb hi = hi_m[mode];

endmodule

// File: rtl/pwm_fsm.sv
module pwm_fsm
    import pwm_dith_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic hi_next,
    input  logic port_bit,
    output logic run,
    output logic pin
);

    pwm_state_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF:  if (en) state_nxt = hi_next ? ST_HIGH : ST_LOW;      // T_START
            ST_HIGH: if (!en)         state_nxt = ST_OFF;                 // T_STOP
                     else if (!hi_next) state_nxt = ST_LOW;               // T_FALL
            ST_LOW:  if (!en)         state_nxt = ST_OFF;                 // T_STOP
                     else if (hi_next)  state_nxt = ST_HIGH;              // T_RISE
            default: state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        run = (state != ST_OFF);
        if (!en) pin = port_bit;
        else     pin = port_bit && (state == ST_HIGH);
    end

    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == ST_OFF); // R7

    AST_RUN_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (!en || state != ST_OFF)); // R1

    AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !port_bit) |-> !pin); // R6

endmodule

// File: rtl/pwm_dither_gen.sv
module pwm_dither_gen
    import pwm_dith_pkg::*;
#(
    parameter int DW    = 8,
    parameter int EXT_A = 2,
    parameter int EXT_B = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sel,
    input  logic [DW-1:0] duty,
    input  logic          pwm_en,
    input  logic          port_bit,
    output logic          pwm_out
);

    logic [DW-1:0] cnt_nxt;
    logic          period_start;
    logic          run;
    logic          hi_next;
    logic [DW-1:0] eff_duty;
    split_mode_e   eff_mode;
    split_mode_e   mode_in;

    always_comb mode_in = split_mode_e'(mode_sel);

    pwm_period_ctr #(.DW(DW)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (pwm_en),
        .run          (run),
        .cnt_nxt      (cnt_nxt),
        .period_start (period_start)
    );

    pwm_duty_shadow #(.DW(DW)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pwm_en && period_start),
        .duty_in  (duty),
        .mode_in  (mode_in),
        .eff_duty (eff_duty),
        .eff_mode (eff_mode)
    );

    pwm_slice_cmp #(.DW(DW), .EXT_A(EXT_A), .EXT_B(EXT_B)) u_cmp (
        .cnt  (cnt_nxt),
        .duty (eff_duty),
        .mode (eff_mode),
        .hi   (hi_next)
    );

    pwm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (pwm_en),
        .hi_next  (hi_next),
        .port_bit (port_bit),
        .run      (run),
        .pin      (pwm_out)
    );

endmodule

// File: tb/test_pwm_dither_gen.sv
`timescale 1ns/1ps
module test_pwm_dither_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b0;
    logic [7:0] duty = 8'd0;
    logic       pwm_en = 1'b0;
    logic       port_bit = 1'b0;
    logic       pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    int m_cnt = 0;
    bit m_run = 1'b0;
    int m_duty = 0;
    int m_mode = 0;

    always #5 clk = ~clk;

    pwm_dither_gen i_pwm_dither_gen (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .duty(duty),
        .pwm_en(pwm_en), .port_bit(port_bit), .pwm_out(pwm_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=running exp=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic bit hi_fn(int c, int d, int md);
        int sub, pos, base, ext;
        if (md == 0) begin sub = c / 64; pos = c % 64; base = d / 4; ext = d % 4; end
        else begin sub = c / 128; pos = c % 128; base = d / 2; ext = d % 2; end
        return pos < base + ((sub < ext) ? 1 : 0);
    endfunction

    function automatic bit exp_out();
        if (!pwm_en) return port_bit;
        return port_bit && m_run && hi_fn(m_cnt, m_duty, m_mode);
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d (cnt=%0d duty=%0d mode=%0d)",
                     tag, act, expv, m_cnt, m_duty, m_mode);
        end
    endtask

    // advance one clock, update the reference, compare at the falling edge
    task automatic step(string tag);
        if (!pwm_en) begin m_run = 0; m_cnt = 0; end
        else if (!m_run) begin m_run = 1; m_cnt = 0; m_duty = duty; m_mode = mode_sel; end
        else begin
            m_cnt = (m_cnt + 1) % 256;
            if (m_cnt == 0) begin m_duty = duty; m_mode = mode_sel; end
        end
        @(posedge clk);
        @(negedge clk);
        chk(pwm_out == exp_out(), tag, pwm_out, exp_out());
    endtask

    task automatic sweep(int md, string tag);
        int hc;
        pwm_en = 0; port_bit = 1; mode_sel = md[0]; duty = 8'd0;
        step("R7");
        pwm_en = 1;
        step(tag);
        for (int d = 0; d < 256; d++) begin
            hc = pwm_out;
            duty = 8'((d + 1) % 256);  // R5: mid-period change must wait
            for (int k = 0; k < 255; k++) begin
                step(tag);
                hc += pwm_out;
            end
            chk(hc == d, "R4", hc, d);
            step(tag);
        end
    endtask

    initial begin
        port_bit = 1;
        #1;
        chk(pwm_out == 1'b1, "R8", pwm_out, 1);
        port_bit = 0;
        #1;
        chk(pwm_out == 1'b0, "R8", pwm_out, 0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        port_bit = 1;
        step("R8");
        step("R8");

        // R1: enabled but not yet started
        duty = 8'd200; mode_sel = 0; pwm_en = 1;
        #1;
        chk(pwm_out == 1'b0, "R1", pwm_out, 0);
        for (int k = 0; k < 300; k++) step("R1");

        sweep(0, "R2");
        sweep(1, "R3");

        // R5: mode and duty change mid-period
        pwm_en = 0; step("R7");
        mode_sel = 0; duty = 8'h4E; pwm_en = 1;
        for (int k = 0; k < 90; k++) step("R5");
        mode_sel = 1; duty = 8'hC3;
        for (int k = 0; k < 520; k++) step("R5");

        // R6: gate toggling while running
        duty = 8'h6B;
        for (int k = 0; k < 600; k++) begin
            if (k % 7 == 0) port_bit = ~port_bit;
            step("R6");
        end

        // R7: disable mid-period, GPIO passthrough, then fresh restart
        port_bit = 1; mode_sel = 0; duty = 8'hA5;
        for (int k = 0; k < 100; k++) step("R7");
        pwm_en = 0;
        for (int k = 0; k < 20; k++) begin
            port_bit = k[0];
            step("R7");
        end
        port_bit = 1; duty = 8'h13; pwm_en = 1;
        for (int k = 0; k < 300; k++) step("R7");

        // extremes in both modes
        duty = 8'hFF;
        for (int k = 0; k < 300; k++) step("R2");
        mode_sel = 1; duty = 8'h01;
        for (int k = 0; k < 520; k++) step("R3");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule